// File: doc/BRIEF.md
# DDR3 Single-Access Command Scheduler

This block turns one memory request at a time from a slow client into the command sequence a DDR3 device needs. Each request is an activate, then a column read or write, then a precharge, or else a refresh. The command bus leaves the block as four-slot parallel words, one word per divided load clock. An external 4:1 serializer shifts each word out at the bit clock. The load clock is a quarter of the bit clock, for example about 83 MHz against 333 MHz. Each control command sits in one chosen slot of its word. Address and bank pins hold the same level in all four slots. The block also drives the DQ tristate, the on-die termination (ODT) enable and a read-capture strobe for the data path.

The client raises `reqValid` with its direction, address, write data and refresh flag. It holds these until `busy` has risen and then fallen again. The block sits in a wait state. When a normal request arrives there, the block builds the row activate combinationally and drives it in the same load cycle, without passing it through the command register. This saves one load-clock cycle of latency. The following commands come from a registered word that the sequencer loads one cycle ahead. The request address is split, from most to least significant, into bank, row and column.

Top module: `ddr3_access_sequencer`

## Requirements
- R1: While `rst` is high and on the first cycle after it, the block outputs a NOP word with all three control pins high in every slot and `csWord` = 4'b0000. In that state `dqTristate` = 1, `odt` = 0, `busy` = 0 and `captureStrobe` = 0.
- R2: Command encoding, given as the active-low levels of (RAS, CAS, WE) in the issuing slot: activate = L,H,H; read = H,L,H; write = H,L,L; precharge = L,H,L; refresh = L,L,H; NOP = H,H,H. `csWord` is 4'b0000 on every cycle.
- R3: A command in slot s (0..3) puts its low levels at bit s of `rasWord`, `casWord` and `weWord`, so slot 0 is the LSB and slot 3 is the MSB. The other three bits of each word are 1.
- R4: Address pin i occupies bits [4i+3:4i] of `addrWord`, and bank pin j occupies bits [4j+3:4j] of `bankWord`. Each of these groups repeats one level in all four bits.
- R5: In the wait state, a valid non-refresh request produces an activate in slot 0 in the same cycle. Its address pins carry the row `reqAddr[ROW_W+COL_W-1:COL_W]`, zero-extended, and its bank pins carry `reqAddr[BANK_W+ROW_W+COL_W-1:ROW_W+COL_W]`.
- R6: One cycle after the activate, the block issues a read, or a write when `reqWrite` = 1, in slot 1. Its address pins carry `reqAddr[COL_W-1:0]` with all higher pins, including A10, at 0. Its bank matches the activate.
- R7: After the column command comes one NOP cycle, then a precharge in slot 3 with address pins 0 and the same bank.
- R8: For a write, `odt` = 1 and `dqTristate` = 0 from the column cycle through the precharge cycle, and `wrData` shows the request data. For a read, `odt` stays 0 and `dqTristate` stays 1. Both return to idle levels on the cycle after the precharge.
- R9: `captureStrobe` is high for exactly the one cycle after a read's precharge. It never goes high for writes or refreshes.
- R10: `busy` rises on the cycle after acceptance. For an access it stays high for 4 cycles and falls on the fifth cycle after acceptance. A new activate can come at the earliest on the cycle after `busy` falls.
- R11: A valid request with `reqRefresh` = 1 has priority over the direction flag. It gives a NOP in the acceptance cycle, then a refresh in slot 0 with address and bank pins 0, then `REF_WAIT` NOP cycles. `busy` is high for `REF_WAIT`+1 cycles, and the sequence issues no activate and never raises `odt`.
- R12: Every cycle that issues no command outputs a NOP word with address and bank pins 0. This includes idle wait cycles with `reqValid` = 0 and the cycle in which `busy` falls.
- R13: A request that is presented outside the wait state has no effect on the command bus. This covers the preparation cycle and the cycles while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Load (divided) clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Client request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqRefresh | input | 1 | Request is a refresh |
| reqAddr | input | BANK_W+ROW_W+COL_W | {bank, row, column} |
| reqData | input | DATA_W | Write data |
| busy | output | 1 | Request in progress; ready when low |
| csWord | output | 4 | Chip-select slots |
| rasWord | output | 4 | RAS slots |
| casWord | output | 4 | CAS slots |
| weWord | output | 4 | WE slots |
| addrWord | output | 4*ADDR_PINS | Address pins, 4 slots each |
| bankWord | output | 4*BANK_W | Bank pins, 4 slots each |
| odt | output | 1 | On-die termination enable |
| dqTristate | output | 1 | 1 = DQ not driven |
| captureStrobe | output | 1 | Read data capture pulse |
| wrData | output | DATA_W | Latched write data for the data path |

## Verification
A bus model in the bench decodes every load-cycle word into a command, a slot, a row or column, and a bank. It compares these against sequences built from the requirements. Random streams mix reads, writes and refreshes with random addresses. This separates the three paths and shows whether the direction and refresh flags steer the encoding and the DQ/ODT controls correctly. Directed cases use all-ones and all-zeros addresses to expose any row/column/bank slicing or zero-extension errors. Requests held through `busy` and presented during the preparation cycle show that only the wait state accepts work. Idle stretches confirm that the output falls back to NOP.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_COL,
    CMD_PRE,
    CMD_REF
  } cmdKind_t;

  typedef enum logic [2:0] {
    ST_PREP,
    ST_WAIT,
    ST_COLUMN,
    ST_RECOVER,
    ST_PRECH,
    ST_POST,
    ST_REFISSUE,
    ST_REFHOLD
  } seqState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic     actNow;     // bypass: drive activate from live request
    logic     latchReq;   // capture address, direction and data
    cmdKind_t nextCmd;    // registered command for the next cycle
    logic [1:0] nextSlot; // slot for that command
    logic     closeBus;   // return ODT / DQ to idle levels
    logic     armCapture; // precharge cycle: arm read capture
  } seqStrobe_t;

  // Active-low levels of {RAS, CAS, WE}
  function automatic logic [2:0] pinLevels(cmdKind_t kind, logic isWrite);
    logic [2:0] lv;
    case (kind)
      CMD_ACT: lv = 3'b011;
      CMD_COL: lv = isWrite ? 3'b100 : 3'b101;
      CMD_PRE: lv = 3'b010;
      CMD_REF: lv = 3'b001;
      default: lv = 3'b111;
    endcase
    return lv;
  endfunction

  // Four-slot word: low level only in the selected slot
  function automatic logic [3:0] slotWord(logic level, logic [1:0] slot);
    return level ? 4'hF : ~(4'h1 << slot);
  endfunction

endpackage

// File: rtl/seq_control.sv
module seq_control
  import seq_pkg::*;
#(
  parameter int REF_WAIT = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  input  logic       reqRefresh,
  output seqStrobe_t strobe,
  output logic       busy
);

  localparam int CNT_W = $clog2(REF_WAIT + 1);

  seqState_t state, stateNext;
  logic [CNT_W-1:0] refCnt;
  logic refDone;
  logic acceptAny;

  assign acceptAny = (state == ST_WAIT) && reqValid;
  assign refDone   = (refCnt == CNT_W'(REF_WAIT - 1));

  always_comb begin
    stateNext         = state;
    strobe            = '0;
    strobe.nextCmd    = CMD_NOP;
    strobe.nextSlot   = 2'd0;
    case (state)
      ST_PREP: stateNext = ST_WAIT;
      ST_WAIT: begin
        if (reqValid) begin
          if (reqRefresh) begin
            stateNext      = ST_REFISSUE;
            strobe.nextCmd = CMD_REF;
          end else begin
            stateNext       = ST_COLUMN;
            strobe.actNow   = 1'b1;
            strobe.latchReq = 1'b1;
            strobe.nextCmd  = CMD_COL;
            strobe.nextSlot = 2'd1;
          end
        end
      end
      ST_COLUMN:  stateNext = ST_RECOVER;
      ST_RECOVER: begin
        stateNext       = ST_PRECH;
        strobe.nextCmd  = CMD_PRE;
        strobe.nextSlot = 2'd3;
      end
      ST_PRECH: begin
        stateNext         = ST_POST;
        strobe.closeBus   = 1'b1;
        strobe.armCapture = 1'b1;
      end
      ST_POST:     stateNext = ST_PREP;
      ST_REFISSUE: stateNext = ST_REFHOLD;
      ST_REFHOLD:  if (refDone) stateNext = ST_PREP;
      default:     stateNext = ST_PREP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_PREP;
      busy   <= 1'b0;
      refCnt <= '0;
    end else begin
      state <= stateNext;
      if (acceptAny)
        busy <= 1'b1;
      else if (state == ST_POST || (state == ST_REFHOLD && refDone))
        busy <= 1'b0;
      if (state == ST_REFHOLD)
        refCnt <= refDone ? '0 : refCnt + 1'b1;
      else
        refCnt <= '0;
    end
  end

  assert_busy_after_accept_R10: assert property (
    @(posedge clk) disable iff (rst) acceptAny |=> busy);

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int BANK_W    = 3,
  parameter int ROW_W     = 6,
  parameter int COL_W     = 10,
  parameter int ADDR_PINS = 14,
  parameter int DATA_W    = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  seqStrobe_t                     strobe,
  input  logic [BANK_W+ROW_W+COL_W-1:0]  reqAddr,
  input  logic                           reqWrite,
  input  logic [DATA_W-1:0]              reqData,
  output logic [3:0]                     csWord,
  output logic [3:0]                     rasWord,
  output logic [3:0]                     casWord,
  output logic [3:0]                     weWord,
  output logic [4*ADDR_PINS-1:0]         addrWord,
  output logic [4*BANK_W-1:0]            bankWord,
  output logic                           odt,
  output logic                           dqTristate,
  output logic                           captureStrobe,
  output logic [DATA_W-1:0]              wrData
);

  localparam int ROW_LSB  = COL_W;
  localparam int BANK_LSB = COL_W + ROW_W;

  cmdKind_t           curCmd;
  logic [1:0]         curSlot;
  logic [COL_W-1:0]   colLatch;
  logic [BANK_W-1:0]  bankLatch;
  logic               wrLatch;

  cmdKind_t              effCmd;
  logic [1:0]            effSlot;
  logic [2:0]            levels;
  logic [ADDR_PINS-1:0]  addrVal;
  logic [BANK_W-1:0]     bankVal;

  always_ff @(posedge clk) begin
    if (rst) begin
      curCmd        <= CMD_NOP;
      curSlot       <= 2'd0;
      colLatch      <= '0;
      bankLatch     <= '0;
      wrLatch       <= 1'b0;
      wrData        <= '0;
      odt           <= 1'b0;
      dqTristate    <= 1'b1;
      captureStrobe <= 1'b0;
    end else begin
      curCmd  <= strobe.nextCmd;
      curSlot <= strobe.nextSlot;
      if (strobe.latchReq) begin
        colLatch   <= reqAddr[COL_W-1:0];
        bankLatch  <= reqAddr[BANK_LSB +: BANK_W];
        wrLatch    <= reqWrite;
        wrData     <= reqData;
        odt        <= reqWrite;
        dqTristate <= !reqWrite;
      end else if (strobe.closeBus) begin
        odt        <= 1'b0;
        dqTristate <= 1'b1;
      end
      captureStrobe <= strobe.armCapture && !wrLatch;
    end
  end

  // Activate bypasses the command register
  assign effCmd  = strobe.actNow ? CMD_ACT : curCmd;
  assign effSlot = strobe.actNow ? 2'd0 : curSlot;
  assign levels  = pinLevels(effCmd, wrLatch);

  always_comb begin
    addrVal = '0;
    bankVal = '0;
    case (effCmd)
      CMD_ACT: begin
        addrVal = ADDR_PINS'(reqAddr[ROW_LSB +: ROW_W]);
        bankVal = reqAddr[BANK_LSB +: BANK_W];
      end
      CMD_COL: begin
        addrVal = ADDR_PINS'(colLatch);
        bankVal = bankLatch;
      end
      CMD_PRE: bankVal = bankLatch;
      default: ;
    endcase
  end

  assign csWord  = 4'h0;
  assign rasWord = slotWord(levels[2], effSlot);
  assign casWord = slotWord(levels[1], effSlot);
  assign weWord  = slotWord(levels[0], effSlot);

  for (genvar i = 0; i < ADDR_PINS; i++) begin : gAddr
    assign addrWord[4*i +: 4] = {4{addrVal[i]}};
  end
  for (genvar j = 0; j < BANK_W; j++) begin : gBank
    assign bankWord[4*j +: 4] = {4{bankVal[j]}};
  end

  assert_col_follows_act_R6: assert property (
    @(posedge clk) disable iff (rst)
    strobe.actNow |=> (curCmd == CMD_COL && curSlot == 2'd1));

  assert_odt_implies_drive_R8: assert property (
    @(posedge clk) disable iff (rst) odt |-> !dqTristate);

  assert_capture_after_read_pre_R9: assert property (
    @(posedge clk) disable iff (rst)
    captureStrobe |-> ($past(curCmd) == CMD_PRE && !wrLatch));

  assert_single_low_slot_R3: assert property (
    @(posedge clk) disable iff (rst)
    $onehot0(~rasWord) && $onehot0(~casWord) && $onehot0(~weWord));

endmodule

// File: rtl/ddr3_access_sequencer.sv
module ddr3_access_sequencer
  import seq_pkg::*;
#(
  parameter int BANK_W    = 3,
  parameter int ROW_W     = 6,
  parameter int COL_W     = 10,
  parameter int ADDR_PINS = 14,
  parameter int DATA_W    = 16,
  parameter int REF_WAIT  = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          reqValid,
  input  logic                          reqWrite,
  input  logic                          reqRefresh,
  input  logic [BANK_W+ROW_W+COL_W-1:0] reqAddr,
  input  logic [DATA_W-1:0]             reqData,
  output logic                          busy,
  output logic [3:0]                    csWord,
  output logic [3:0]                    rasWord,
  output logic [3:0]                    casWord,
  output logic [3:0]                    weWord,
  output logic [4*ADDR_PINS-1:0]        addrWord,
  output logic [4*BANK_W-1:0]           bankWord,
  output logic                          odt,
  output logic                          dqTristate,
  output logic                          captureStrobe,
  output logic [DATA_W-1:0]             wrData
);

  seqStrobe_t strobe;

  seq_control #(.REF_WAIT(REF_WAIT)) uControl (
    .clk        (clk),
    .rst        (rst),
    .reqValid   (reqValid),
    .reqRefresh (reqRefresh),
    .strobe     (strobe),
    .busy       (busy)
  );

  seq_datapath #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .ADDR_PINS(ADDR_PINS), .DATA_W(DATA_W)
  ) uDatapath (
    .clk           (clk),
    .rst           (rst),
    .strobe        (strobe),
    .reqAddr       (reqAddr),
    .reqWrite      (reqWrite),
    .reqData       (reqData),
    .csWord        (csWord),
    .rasWord       (rasWord),
    .casWord       (casWord),
    .weWord        (weWord),
    .addrWord      (addrWord),
    .bankWord      (bankWord),
    .odt           (odt),
    .dqTristate    (dqTristate),
    .captureStrobe (captureStrobe),
    .wrData        (wrData)
  );

  assert_nop_when_ready_R12: assert property (
    @(posedge clk) disable iff (rst)
    $fell(busy) |-> ((rasWord & casWord & weWord) == 4'hF));

endmodule

// File: tb/ddr3_access_sequencer_test.sv
module ddr3_access_sequencer_test;

  localparam int BANK_W = 3, ROW_W = 6, COL_W = 10, ADDR_PINS = 14;
  localparam int DATA_W = 16, REF_WAIT = 8;
  localparam int REQ_W = BANK_W + ROW_W + COL_W;

  logic clk = 1'b0, rst = 1'b1;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqRefresh = 1'b0;
  logic [REQ_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqData = '0;
  logic busy, odt, dqTristate, captureStrobe;
  logic [3:0] csWord, rasWord, casWord, weWord;
  logic [4*ADDR_PINS-1:0] addrWord;
  logic [4*BANK_W-1:0] bankWord;
  logic [DATA_W-1:0] wrData;

  int errCnt = 0, chkCnt = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ddr3_access_sequencer #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .ADDR_PINS(ADDR_PINS), .DATA_W(DATA_W), .REF_WAIT(REF_WAIT)
  ) uut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] expWord(logic level, int slot);
    return level ? 4'hF : ~(4'h1 << slot);
  endfunction

  function automatic logic [4*ADDR_PINS-1:0] repAddr(logic [ADDR_PINS-1:0] v);
    logic [4*ADDR_PINS-1:0] r;
    for (int i = 0; i < ADDR_PINS; i++) r[4*i +: 4] = {4{v[i]}};
    return r;
  endfunction

  function automatic logic [4*BANK_W-1:0] repBank(logic [BANK_W-1:0] v);
    logic [4*BANK_W-1:0] r;
    for (int i = 0; i < BANK_W; i++) r[4*i +: 4] = {4{v[i]}};
    return r;
  endfunction

  // Bus model check: levels = {RAS,CAS,WE} active-low (R2), slot (R3), pins (R4)
  task automatic busChk(input string tag, input logic [2:0] lv, input int slot,
                        input logic [ADDR_PINS-1:0] a, input logic [BANK_W-1:0] b);
    chk({tag, " cmd R2 R3"}, {rasWord, casWord, weWord},
        {expWord(lv[2], slot), expWord(lv[1], slot), expWord(lv[0], slot)});
    chk({tag, " cs R2"}, csWord, 4'h0);
    chk({tag, " addr R4"}, addrWord, repAddr(a));
    chk({tag, " bank R4"}, bankWord, repBank(b));
  endtask

  task automatic access(input logic wr, input logic [REQ_W-1:0] addr, input logic [DATA_W-1:0] data);
    logic [BANK_W-1:0] bk = addr[REQ_W-1 -: BANK_W];
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqRefresh = 0; reqAddr = addr; reqData = data;
    #1;
    busChk("R5 activate", 3'b011, 0, ADDR_PINS'(addr[COL_W +: ROW_W]), bk);
    chk("R10 busy low at accept", busy, 0);
    @(negedge clk);
    busChk("R6 column", wr ? 3'b100 : 3'b101, 1, ADDR_PINS'(addr[COL_W-1:0]), bk);
    chk("R10 busy rises", busy, 1);
    chk("R8 odt", odt, wr);
    chk("R8 tristate", dqTristate, !wr);
    if (wr) chk("R8 wrData", wrData, data);
    @(negedge clk);
    busChk("R7 recovery nop R13", 3'b111, 0, '0, '0);
    chk("R8 odt hold", odt, wr);
    @(negedge clk);
    busChk("R7 precharge", 3'b010, 3, '0, bk);
    chk("R8 tristate hold", dqTristate, !wr);
    chk("R9 no early capture", captureStrobe, 0);
    @(negedge clk);
    busChk("R12 post nop R13", 3'b111, 0, '0, '0);
    chk("R9 capture", captureStrobe, !wr);
    chk("R8 odt idle", odt, 0);
    chk("R8 tristate idle", dqTristate, 1);
    chk("R10 busy still high", busy, 1);
    @(negedge clk);
    chk("R10 busy falls", busy, 0);
    chk("R9 capture one cycle", captureStrobe, 0);
    busChk("R12 ready nop R13", 3'b111, 0, '0, '0);
    reqValid = 0;
  endtask

  task automatic refresh(input logic wr, input logic [REQ_W-1:0] addr);
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqRefresh = 1; reqAddr = addr;
    #1;
    busChk("R11 accept nop", 3'b111, 0, '0, '0);
    @(negedge clk);
    busChk("R11 refresh", 3'b001, 0, '0, '0);
    chk("R11 busy", busy, 1);
    for (int j = 0; j < REF_WAIT; j++) begin
      @(negedge clk);
      busChk("R11 hold nop", 3'b111, 0, '0, '0);
      chk("R11 busy hold", busy, 1);
      chk("R11 odt low", odt, 0);
    end
    @(negedge clk);
    chk("R11 busy falls", busy, 0);
    chk("R9 no capture on refresh", captureStrobe, 0);
    reqValid = 0; reqRefresh = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reqValid = 0;
      #1;
      busChk("R12 idle", 3'b111, 0, '0, '0);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errCnt++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    // R1: reset state
    busChk("R1 reset", 3'b111, 0, '0, '0);
    chk("R1 tristate", dqTristate, 1);
    chk("R1 odt", odt, 0);
    chk("R1 busy", busy, 0);
    chk("R1 capture", captureStrobe, 0);
    // Release reset with a request already present: preparation cycle ignores it (R13)
    rst = 0; reqValid = 1; reqWrite = 0; reqAddr = '1;
    #1;
    busChk("R13 prep ignores request R1", 3'b111, 0, '0, '0);
    chk("R1 busy after reset", busy, 0);
    // Directed corners
    access(1'b0, '1, 16'h0);
    idle(1);
    access(1'b1, '0, 16'hA5C3);
    idle(1);
    access(1'b1, {BANK_W'(5), ROW_W'(6'h2A), COL_W'(10'h3FF)}, 16'hFFFF);
    access(1'b0, {BANK_W'(2), ROW_W'(6'h15), COL_W'(10'h155)}, 16'h1234);
    refresh(1'b1, '1);
    idle(3);
    // Random mix
    for (int n = 0; n < 60; n++) begin
      r = $urandom;
      if (r[2:0] == 3'd0)
        refresh(r[3], REQ_W'($urandom));
      else
        access(r[3], REQ_W'($urandom), DATA_W'($urandom));
      if (r[4]) idle(int'(r[6:5]) + 1);
    end
    idle(2);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule